// File: doc/BRIEF.md
# Multi-Format Audio Serial Data Port

This block moves PCM samples between parallel registers and a four-wire serial audio link: a bit clock, a word clock, a serial input and a serial output. The bit clock and the word clock arrive as inputs. They may come from another device or from a local divider. The block oversamples them with its own system clock. A single slot map covers five framings: I2S, left-justified, right-justified, a two-channel DSP framing and a multichannel TDM framing with up to `NUM_CH` slots. Word length, data offset, bit-clock polarity and tri-state behaviour are set by static configuration inputs.

On the transmit side, a whole frame of channel lanes is handed over through a valid/ready handshake. The lanes are held in a staging register and are sent starting at the next frame start. If nothing is staged, zeros go out. On the receive side, each finished channel sample is presented right-aligned, with its channel index and a one-cycle strobe. The serial output has a separate enable. In TDM, several devices can then drive one data line, each in its own slots.

Top module: `aud_serial_port`

## Requirements
- R1: After reset, `dout` and `dout_oe` are 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: Every sample is shifted most significant bit first. `cfg_wlen` selects the word length: 00=16, 01=20, 10=24, 11=32 bits. Samples occupy the low bits of each 32-bit lane, and received samples have zeros above the word length.
- R3: With `cfg_fmt`=0 (I2S), a low word clock marks the left channel (index 0) and a high word clock marks the right channel (index 1). The first data bit falls in the second bit-clock slot after each word-clock transition, plus the offset.
- R4: With `cfg_fmt`=1 (left-justified), a high word clock marks the left channel (index 0). The first data bit falls in the first slot after the transition, plus the offset.
- R5: With `cfg_fmt`=2 (right-justified), a high word clock marks the left channel. The last data bit falls in the last slot of a half-frame that is `cfg_slot_len` bit clocks long, and `cfg_offset` has no effect.
- R6: With `cfg_fmt`=3 (DSP), a rising word clock marks the frame start. Channels 0 and 1 follow back to back, starting one slot after the sync slot plus the offset.
- R7: With `cfg_fmt`=4 (TDM), a rising word clock marks the frame start. `NUM_CH` channels follow back to back, starting at the sync slot plus the offset.
- R8: `cfg_offset` delays the first data bit by that many bit clocks in every format except right-justified.
- R9: With `cfg_bclk_inv`=0, data is launched on the falling bit-clock edge and captured on the rising edge. With 1, the two edges swap. `dout` and `dout_oe` change only at launch edges.
- R10: With `cfg_hiz`=1, `dout_oe` is low during every slot that carries no data. With 0, `dout_oe` is high from the first launch edge on. `dout` is 0 in idle slots.
- R11: Each received channel raises `rx_valid` for exactly one cycle, with `rx_data` and `rx_chan`. Nothing is received before the first frame start after reset.
- R12: `tx_ready` is high while the staging register is empty. A staged frame is sent in the next frame, and a frame with nothing staged sends zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock |
| wclk_in | input | 1 | Word clock / frame sync |
| din | input | 1 | Serial receive data |
| cfg_fmt | input | 3 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP, 4 TDM |
| cfg_wlen | input | 2 | Word length code |
| cfg_offset | input | OFS_W | Data offset in bit clocks |
| cfg_slot_len | input | OFS_W | Half-frame length in bit clocks (right-justified) |
| cfg_bclk_inv | input | 1 | Swap launch and capture edges |
| cfg_hiz | input | 1 | Release `dout_oe` in idle slots |
| tx_data | input | NUM_CH*32 | Transmit lanes, lane n in bits n*32+31..n*32 |
| tx_valid | input | 1 | Transmit frame offered |
| tx_ready | output | 1 | Staging register empty |
| rx_data | output | 32 | Received sample, right-aligned |
| rx_chan | output | 3 | Channel index of `rx_data` |
| rx_valid | output | 1 | One-cycle strobe for a received sample |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The bench goes after the slot on which the first bit lands in each framing: the I2S one-slot delay, the right-justified alignment to the end of the half-frame with a non-zero offset that must be ignored, and the DSP versus TDM start slots. A design that miscounts any of these shifts every sample by a bit, so both the serial output check and the received-sample scoreboard report it. Inverted bit-clock polarity is run so that swapped launch and capture edges would corrupt the data. A frame with no staged data checks that zeros go out rather than the previous frame repeated. With tri-state enabled, the output enable is compared slot by slot, so an enable that leaks into an idle slot is caught.

// File: rtl/aud_sp_pkg.sv
package aud_sp_pkg;

    localparam int SLOT_MAX = 8;
    localparam int CH_W     = 3;
    localparam int BIT_W    = 5;
    localparam int LANE_W   = 32;

    typedef enum logic [2:0] {
        FMT_I2S = 3'd0,
        FMT_LJ  = 3'd1,
        FMT_RJ  = 3'd2,
        FMT_DSP = 3'd3,
        FMT_TDM = 3'd4
    } fmt_e;

    typedef struct packed {
        logic             active;
        logic [CH_W-1:0]  ch;
        logic [BIT_W-1:0] bitn;
    } slot_t;

    typedef struct packed {
        logic bclk;
        logic wclk;
        logic din;
    } pins_t;

    function automatic int wlen_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 20;
            2'b10:   return 24;
            default: return 32;
        endcase
    endfunction

    function automatic logic is_pulse_fmt(input fmt_e fmt);
        return (fmt == FMT_DSP) || (fmt == FMT_TDM);
    endfunction

    // Maps a slot position inside the current (half-)frame to channel and bit.
    function automatic slot_t slot_map(input fmt_e fmt, input logic [1:0] wcode,
                                       input int off, input int slen,
                                       input logic side, input int pos,
                                       input int nch);
        slot_t r;
        int    wl;
        int    start;
        int    cnt;
        int    base;
        int    rel;
        int    idx;
        r     = '0;
        wl    = wlen_bits(wcode);
        start = 0;
        cnt   = 0;
        base  = 0;
        case (fmt)
            FMT_I2S: begin start = 1 + off;   cnt = 1; base = side ? 1 : 0; end
            FMT_LJ:  begin start = off;       cnt = 1; base = side ? 0 : 1; end
            FMT_RJ:  begin start = slen - wl; cnt = 1; base = side ? 0 : 1; end
            FMT_DSP: begin start = 1 + off;   cnt = 2; end
            FMT_TDM: begin start = off;       cnt = (nch > SLOT_MAX) ? SLOT_MAX : nch; end
            default: cnt = 0;
        endcase
        rel = pos - start;
        idx = 0;
        if (rel >= 0 && rel < cnt * wl) begin
            for (int k = 1; k < SLOT_MAX; k++) begin
                if (k < cnt && rel >= k * wl) idx = k;
            end
            r.active = 1'b1;
            r.ch     = CH_W'(base + idx);
            r.bitn   = BIT_W'(wl - 1 - (rel - idx * wl));
        end
        return r;
    endfunction

endpackage

// File: rtl/aud_sp_sync.sv
module aud_sp_sync
    import aud_sp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic inv,
    input  logic bclk_in,
    input  logic wclk_in,
    input  logic din,
    output logic launch,
    output logic capture,
    output logic wclk_s,
    output logic din_s
);
    pins_t s1_q;
    logic  bclk_d_q;
    logic  rise;
    logic  fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q     <= '0;
            bclk_d_q <= 1'b0;
        end else begin
            s1_q     <= '{bclk: bclk_in, wclk: wclk_in, din: din};
            bclk_d_q <= s1_q.bclk;
        end
    end

    always_comb begin
        rise    = s1_q.bclk & ~bclk_d_q;
        fall    = ~s1_q.bclk & bclk_d_q;
        launch  = inv ? rise : fall;
        capture = inv ? fall : rise;
        wclk_s  = s1_q.wclk;
        din_s   = s1_q.din;
    end

endmodule

// File: rtl/aud_sp_timer.sv
module aud_sp_timer
    import aud_sp_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int POS_W  = 9,
    parameter int OFS_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             wclk_s,
    input  fmt_e             fmt,
    input  logic [1:0]       wcode,
    input  logic [OFS_W-1:0] offset,
    input  logic [OFS_W-1:0] slot_len,
    output slot_t            nxt_slot,
    output slot_t            cur_slot,
    output logic             frame_start
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_n;
    logic             wprev_q;
    logic             synced_q;
    logic             boundary;
    slot_t            map;
    slot_t            cur_q;

    always_comb begin
        if (is_pulse_fmt(fmt)) boundary = wclk_s & ~wprev_q;
        else                   boundary = wclk_s ^ wprev_q;
        frame_start = launch & boundary & ((fmt == FMT_I2S) ? ~wclk_s : wclk_s);
        if (boundary)             pos_n = '0;
        else if (pos_q == POS_MAX) pos_n = pos_q;
        else                      pos_n = pos_q + 1'b1;
        map = slot_map(fmt, wcode, int'(offset), int'(slot_len), wclk_s,
                       int'(pos_n), NUM_CH);
        nxt_slot        = map;
        nxt_slot.active = map.active & (synced_q | frame_start);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= POS_MAX;
            wprev_q  <= 1'b0;
            synced_q <= 1'b0;
            cur_q    <= '0;
        end else if (launch) begin
            pos_q   <= pos_n;
            wprev_q <= wclk_s;
            cur_q   <= nxt_slot;
            if (frame_start) synced_q <= 1'b1;
        end
    end

    assign cur_slot = cur_q;

    // R11
    active_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
        cur_q.active |-> synced_q);

endmodule

// File: rtl/aud_sp_tx.sv
module aud_sp_tx
    import aud_sp_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     launch,
    input  logic                     frame_start,
    input  slot_t                    nxt_slot,
    input  logic                     hiz,
    input  logic [NUM_CH*LANE_W-1:0] tx_data,
    input  logic                     tx_valid,
    output logic                     tx_ready,
    output logic                     dout,
    output logic                     dout_oe
);
    localparam int FRAME_W = NUM_CH * LANE_W;

    logic [FRAME_W-1:0] pend_q;
    logic               pend_full_q;
    logic [FRAME_W-1:0] cur_q;
    logic [FRAME_W-1:0] src;
    logic [LANE_W-1:0]  lane;
    logic               bit_val;
    logic               dout_q;
    logic               oe_q;

    always_comb begin
        if (frame_start) src = pend_full_q ? pend_q : '0;
        else             src = cur_q;
        lane = '0;
        for (int g = 0; g < NUM_CH; g++) begin
            if (int'(nxt_slot.ch) == g) lane = src[g*LANE_W +: LANE_W];
        end
        bit_val = nxt_slot.active & lane[nxt_slot.bitn];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            pend_full_q <= 1'b0;
            cur_q       <= '0;
            dout_q      <= 1'b0;
            oe_q        <= 1'b0;
        end else begin
            if (tx_valid && !pend_full_q) begin
                pend_q      <= tx_data;
                pend_full_q <= 1'b1;
            end
            if (launch) begin
                if (frame_start) begin
                    cur_q <= src;
                    if (pend_full_q) pend_full_q <= 1'b0;
                end
                dout_q <= bit_val;
                oe_q   <= nxt_slot.active | ~hiz;
            end
        end
    end

    assign tx_ready = ~pend_full_q;
    assign dout     = dout_q;
    assign dout_oe  = oe_q;

    // R12
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_ready && !(launch && frame_start)) |=> !tx_ready);

    // R9
    launch_only_chk: assert property (@(posedge clk) disable iff (rst)
        !launch |=> ($stable(dout) && $stable(dout_oe)));

endmodule

// File: rtl/aud_sp_rx.sv
module aud_sp_rx
    import aud_sp_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic              din_s,
    input  slot_t             cur_slot,
    input  fmt_e              fmt,
    input  logic [1:0]        wcode,
    output logic [LANE_W-1:0] rx_data,
    output logic [CH_W-1:0]   rx_chan,
    output logic              rx_valid
);
    logic [LANE_W-1:0] sh_q;
    logic [LANE_W-1:0] sh_n;
    logic [LANE_W-1:0] data_q;
    logic [CH_W-1:0]   chan_q;
    logic              valid_q;
    logic              first_bit;

    always_comb begin
        first_bit = (int'(cur_slot.bitn) == wlen_bits(wcode) - 1);
        if (first_bit) sh_n = {{(LANE_W-1){1'b0}}, din_s};
        else           sh_n = {sh_q[LANE_W-2:0], din_s};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            data_q  <= '0;
            chan_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (capture && cur_slot.active) begin
                sh_q <= sh_n;
                if (cur_slot.bitn == '0) begin
                    data_q  <= sh_n;
                    chan_q  <= cur_slot.ch;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign rx_data  = data_q;
    assign rx_chan  = chan_q;
    assign rx_valid = valid_q;

    // R11
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R11
    chan_range_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (int'(rx_chan) < ((fmt == FMT_TDM) ? NUM_CH : 2)));

    // R2
    word_fit_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> ((rx_data >> wlen_bits(wcode)) == '0));

endmodule

// File: rtl/aud_serial_port.sv
module aud_serial_port
    import aud_sp_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int POS_W  = 9,
    parameter int OFS_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bclk_in,
    input  logic                     wclk_in,
    input  logic                     din,
    input  logic [2:0]               cfg_fmt,
    input  logic [1:0]               cfg_wlen,
    input  logic [OFS_W-1:0]         cfg_offset,
    input  logic [OFS_W-1:0]         cfg_slot_len,
    input  logic                     cfg_bclk_inv,
    input  logic                     cfg_hiz,
    input  logic [NUM_CH*LANE_W-1:0] tx_data,
    input  logic                     tx_valid,
    output logic                     tx_ready,
    output logic [LANE_W-1:0]        rx_data,
    output logic [CH_W-1:0]          rx_chan,
    output logic                     rx_valid,
    output logic                     dout,
    output logic                     dout_oe
);
    fmt_e  fmt;
    logic  launch;
    logic  capture;
    logic  wclk_s;
    logic  din_s;
    logic  frame_start;
    slot_t nxt_slot;
    slot_t cur_slot;

    assign fmt = fmt_e'(cfg_fmt);

    aud_sp_sync u_sync (
        .clk     (clk),
        .rst     (rst),
        .inv     (cfg_bclk_inv),
        .bclk_in (bclk_in),
        .wclk_in (wclk_in),
        .din     (din),
        .launch  (launch),
        .capture (capture),
        .wclk_s  (wclk_s),
        .din_s   (din_s)
    );

    aud_sp_timer #(.NUM_CH(NUM_CH), .POS_W(POS_W), .OFS_W(OFS_W)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .wclk_s      (wclk_s),
        .fmt         (fmt),
        .wcode       (cfg_wlen),
        .offset      (cfg_offset),
        .slot_len    (cfg_slot_len),
        .nxt_slot    (nxt_slot),
        .cur_slot    (cur_slot),
        .frame_start (frame_start)
    );

    aud_sp_tx #(.NUM_CH(NUM_CH)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .frame_start (frame_start),
        .nxt_slot    (nxt_slot),
        .hiz         (cfg_hiz),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .dout        (dout),
        .dout_oe     (dout_oe)
    );

    aud_sp_rx #(.NUM_CH(NUM_CH)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .din_s    (din_s),
        .cur_slot (cur_slot),
        .fmt      (fmt),
        .wcode    (cfg_wlen),
        .rx_data  (rx_data),
        .rx_chan  (rx_chan),
        .rx_valid (rx_valid)
    );

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_hiz && !dout_oe) |-> !dout);

endmodule

// File: tb/aud_serial_port_tb_top.sv
module aud_serial_port_tb_top;
    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bclk_in = 1'b0;
    logic            wclk_in = 1'b0;
    logic            din = 1'b0;
    logic [2:0]      cfg_fmt = 3'd0;
    logic [1:0]      cfg_wlen = 2'b00;
    logic [7:0]      cfg_offset = 8'd0;
    logic [7:0]      cfg_slot_len = 8'd32;
    logic            cfg_bclk_inv = 1'b0;
    logic            cfg_hiz = 1'b0;
    logic [NCH*32-1:0] tx_data = '0;
    logic            tx_valid = 1'b0;
    logic            tx_ready;
    logic [31:0]     rx_data;
    logic [2:0]      rx_chan;
    logic            rx_valid;
    logic            dout;
    logic            dout_oe;

    int total = 0;
    int bad = 0;
    logic [34:0] exp_q[$];

    always #5 clk = ~clk;

    aud_serial_port #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst(rst), .bclk_in(bclk_in), .wclk_in(wclk_in), .din(din),
        .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_offset(cfg_offset),
        .cfg_slot_len(cfg_slot_len), .cfg_bclk_inv(cfg_bclk_inv), .cfg_hiz(cfg_hiz),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_chan(rx_chan), .rx_valid(rx_valid),
        .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [31:0] txpat(input int f, input int l);
        return 32'h1234_5678 ^ (32'(f) * 32'h9E37_79B9) ^ (32'(l) * 32'h7F4A_7C15);
    endfunction

    function automatic logic [31:0] rxpat(input int f, input int l);
        return 32'hC0DE_5A5A ^ (32'(f) * 32'h2545_F491) ^ (32'(l) * 32'h0BAD_F00D);
    endfunction

    function automatic int wl_of(input logic [1:0] c);
        return (c == 2'b00) ? 16 : (c == 2'b01) ? 20 : (c == 2'b10) ? 24 : 32;
    endfunction

    function automatic logic [31:0] mask_of(input int wl);
        return (wl == 32) ? 32'hFFFF_FFFF : ((32'd1 << wl) - 32'd1);
    endfunction

    // Expected slot content, computed from the framing rules of R3..R8.
    task automatic exp_slot(input int fmt, input int wl, input int off, input int slen,
                            input int half, input int p,
                            output logic act, output int ch, output int bitn);
        int nch;
        int base;
        int start;
        act = 1'b0; ch = 0; bitn = 0;
        nch = 1; base = half; start = 0;
        case (fmt)
            0: start = 1 + off;
            1: start = off;
            2: start = slen - wl;
            3: begin start = 1 + off; nch = 2; base = 0; end
            default: begin start = off; nch = NCH; base = 0; end
        endcase
        for (int c = 0; c < nch; c++) begin
            int lo;
            lo = start + c * wl;
            if (p >= lo && p < lo + wl) begin
                act = 1'b1; ch = base + c; bitn = wl - 1 - (p - lo);
            end
        end
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp,
                         input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected received samples as the design presents them.
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected sample: actual=%0h/%0d expected=none",
                         rx_data, rx_chan);
            end else begin
                logic [34:0] e;
                e = exp_q.pop_front();
                if ({rx_chan, rx_data} !== e) begin
                    bad++;
                    $display("FAIL R11 R2 rx sample: actual=%0d/%0h expected=%0d/%0h",
                             rx_chan, rx_data, e[34:32], e[31:0]);
                end
            end
        end
    end

    task automatic run_case(input string tag, input int fmt, input logic [1:0] wc,
                            input int off, input int slen, input logic inv, input logic hiz,
                            input int nframes, input int nodata);
        int  wl;
        int  flen;
        int  nch_tot;
        logic lead_w;
        logic last_w;
        logic cap_lvl;
        wl = wl_of(wc);
        cap_lvl = ~inv;
        nch_tot = (fmt == 4) ? NCH : 2;
        flen = (fmt >= 3) ? slen : 2 * slen;
        lead_w = (fmt == 0) ? 1'b1 : 1'b0;
        @(negedge clk);
        cfg_fmt = 3'(fmt); cfg_wlen = wc; cfg_offset = 8'(off); cfg_slot_len = 8'(slen);
        cfg_bclk_inv = inv; cfg_hiz = hiz;
        bclk_in = cap_lvl; wclk_in = lead_w; din = 1'b0; tx_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1", {63'b0, dout}, 64'd0, "reset dout");
        check("R1", {63'b0, dout_oe}, 64'd0, "reset dout_oe");
        check("R1", {63'b0, rx_valid}, 64'd0, "reset rx_valid");
        check("R1", {63'b0, tx_ready}, 64'd1, "reset tx_ready");
        for (int s = 0; s < 2; s++) begin
            bclk_in = ~cap_lvl; repeat (4) @(negedge clk);
            bclk_in = cap_lvl;  repeat (4) @(negedge clk);
        end
        last_w = lead_w;
        for (int f = 0; f < nframes; f++) begin
            if (f != nodata) begin
                while (!tx_ready) @(negedge clk);
                for (int l = 0; l < NCH; l++) tx_data[l*32 +: 32] = txpat(f, l);
                tx_valid = 1'b1;
                @(negedge clk);
                tx_valid = 1'b0;
                // R12
                check("R12", {63'b0, tx_ready}, 64'd0, "tx_ready after accept");
            end
            for (int c = 0; c < nch_tot; c++)
                exp_q.push_back({3'(c), rxpat(f, c) & mask_of(wl)});
            for (int s = 0; s < flen; s++) begin
                int   half;
                int   p;
                logic act;
                int   ch;
                int   bn;
                logic [31:0] tv;
                logic exp_d;
                logic exp_oe;
                half = (fmt >= 3) ? 0 : s / slen;
                p    = (fmt >= 3) ? s : s % slen;
                exp_slot(fmt, wl, off, slen, half, p, act, ch, bn);
                if (fmt >= 3)      last_w = (s == 0);
                else if (fmt == 0) last_w = (half == 1);
                else               last_w = (half == 0);
                tv = rxpat(f, ch);
                bclk_in = ~cap_lvl;
                wclk_in = last_w;
                din     = act ? tv[bn] : 1'b0;
                repeat (4) @(negedge clk);
                tv = (f == nodata) ? 32'd0 : txpat(f, ch);
                exp_d  = act ? tv[bn] : 1'b0;
                exp_oe = act | ~hiz;
                check(tag, {63'b0, dout}, {63'b0, exp_d}, $sformatf("dout f%0d s%0d", f, s));
                check(tag, {63'b0, dout_oe}, {63'b0, exp_oe}, $sformatf("dout_oe f%0d s%0d", f, s));
                bclk_in = cap_lvl;
                repeat (4) @(negedge clk);
            end
        end
        for (int s = 0; s < 3; s++) begin
            bclk_in = ~cap_lvl; wclk_in = last_w & (fmt < 3); din = 1'b0;
            repeat (4) @(negedge clk);
            bclk_in = cap_lvl; repeat (4) @(negedge clk);
        end
        // R11
        check("R11", 64'(exp_q.size()), 64'd0, "samples left undelivered");
        exp_q.delete();
    endtask

    bit done = 1'b0;

    initial begin
        // R3: I2S, 16-bit, one delay slot
        run_case("R3 R2", 0, 2'b00, 0, 32, 1'b0, 1'b0, 2, 99);
        // R4 R8 R9 R10: left-justified, 24-bit, offset 2, inverted clock, tri-state
        run_case("R4 R8 R9 R10", 1, 2'b10, 2, 32, 1'b1, 1'b1, 2, 99);
        // R5: right-justified, 20-bit, offset must be ignored
        run_case("R5 R10", 2, 2'b01, 5, 24, 1'b0, 1'b1, 2, 99);
        // R6 R8: DSP, 32-bit, offset 1
        run_case("R6 R8 R2", 3, 2'b11, 1, 70, 1'b0, 1'b1, 2, 99);
        // R7 R12: TDM, 16-bit, offset 3, inverted clock, second frame without data
        run_case("R7 R12 R9", 4, 2'b00, 3, 70, 1'b1, 1'b1, 3, 1);
        // R12: I2S with no data staged for the first frame
        run_case("R12 R3", 0, 2'b01, 1, 24, 1'b0, 1'b0, 2, 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule